// File: doc/BRIEF.md
# Panel Sync Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and active-video strobes for a flat-panel output. It runs on the panel pixel clock. A horizontal counter steps once per clock and wraps at a programmed maximum. A vertical counter steps each time the horizontal counter wraps. Every strobe edge is a programmed 11-bit position. The data-enable window is meant to cover a border around the picture, so it is usually wider than the active-video window, which has its own start and stop positions. The vertical sync pulse begins at the first pixel of line 0. It ends at a programmed pixel inside a programmed line, not at the start of a line.

Positions are written one byte at a time through a small write port. Each 11-bit position takes a pair of adjacent byte addresses. Writes go into staging storage. The block copies all staged values into the working set in one step, at the clock where the counters wrap from the last pixel of the last line. A new timing set can therefore be written across many cycles without upsetting the frame in progress.

Top module: `panel_timing_gen`

## Requirements
- R1: A synchronous reset clears both counters and drives hSync, vSync, dataEn, activeVid, pixCount and lineCount to 0 on the clock after it is sampled. Reset also returns both the staged and the working values to these defaults: lineMax 63, hsOn 4, hsOff 12, deOn 16, deOff 56, actOn 20, actOff 52, vsEndLine 2, vsEndPix 30, frameMax 15, vdeOn 3, vdeOff 13.
- R2: Value k (0 to 11) is written through two byte addresses. Address BASE_ADDR+2k (218+2k by default) writes bits 7:0. Address BASE_ADDR+2k+1 writes bits 10:8 from data bits 2:0; the upper five data bits are ignored. Writes to any other address change nothing. The index order is: 0 lineMax, 1 hsOn, 2 hsOff, 3 deOn, 4 deOff, 5 actOn, 6 actOff, 7 vsEndLine, 8 vsEndPix, 9 frameMax, 10 vdeOn, 11 vdeOff.
- R3: Written values reach the timing only at a frame boundary. That is the clock where the pixel counter is at lineMax and the line counter is at frameMax. All twelve values switch together there.
- R4: pixCount runs 0, 1, …, lineMax and then returns to 0. lineCount increments when pixCount wraps and returns to 0 after frameMax. The first clock after reset shows pixel 0 of line 0. Each output cycle's strobes belong to the pixCount and lineCount shown on that same cycle.
- R5: hSync is high exactly when hsOn ≤ pixCount < hsOff.
- R6: dataEn is high exactly when deOn ≤ pixCount < deOff and vdeOn ≤ lineCount < vdeOff.
- R7: activeVid is high exactly when actOn ≤ pixCount < actOff and vdeOn ≤ lineCount < vdeOff.
- R8: vSync is high from pixel 0 of line 0 up to, but not including, pixel vsEndPix of line vsEndLine. It is high when lineCount < vsEndLine, or when lineCount = vsEndLine and pixCount < vsEndPix.
- R9: Any window whose start value is greater than or equal to its end value keeps its strobe low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Panel pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Byte write strobe |
| regAddr | input | 8 | Byte address of the write |
| regWrData | input | 8 | Byte being written |
| hSync | output | 1 | Horizontal sync strobe |
| vSync | output | 1 | Vertical sync strobe |
| dataEn | output | 1 | Data-enable strobe (border plus picture) |
| activeVid | output | 1 | Active-picture flag |
| pixCount | output | 11 | Pixel position of the current output cycle |
| lineCount | output | 11 | Line position of the current output cycle |

## Verification
The hardest case to reach from the ports is a write that lands while a frame is running. Half of a value may already be staged. The frame must keep its old line length until the boundary, and then the whole new set must apply on the exact wrap clock. The stimulus waits for a known mid-frame position, rewrites only the low byte of the line length, and records the largest pixel count before and after the boundary. Random timing sets are written with stray writes to out-of-range addresses mixed in, including writes that fall during a frame wrap. A per-cycle reference model stages and switches values the same way, so a wrong load moment shows up as a count mismatch.

// File: rtl/ptg_pkg.sv
`timescale 1ns/1ps
package ptg_pkg;
  localparam int POS_W   = 11;
  localparam int BYTE_W  = 8;
  localparam int HI_W    = POS_W - BYTE_W;
  localparam int NUM_POS = 12;

  // Position indices; the index order fixes the byte-pair address map
  localparam int IDX_LINE_MAX   = 0;
  localparam int IDX_HS_ON      = 1;
  localparam int IDX_HS_OFF     = 2;
  localparam int IDX_DE_ON      = 3;
  localparam int IDX_DE_OFF     = 4;
  localparam int IDX_ACT_ON     = 5;
  localparam int IDX_ACT_OFF    = 6;
  localparam int IDX_VS_END_LN  = 7;
  localparam int IDX_VS_END_PX  = 8;
  localparam int IDX_FRAME_MAX  = 9;
  localparam int IDX_VDE_ON     = 10;
  localparam int IDX_VDE_OFF    = 11;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [NUM_POS-1:0][POS_W-1:0] cfg_vec_t;

  // Strobes and counts passed from control to datapath
  typedef struct packed {
    pos_t hCnt;
    pos_t vCnt;
    logic lineWrap;
    logic frameWrap;
  } ptg_strobe_t;

  function automatic pos_t resetPos(input int idx);
    case (idx)
      IDX_LINE_MAX:  return POS_W'(63);
      IDX_HS_ON:     return POS_W'(4);
      IDX_HS_OFF:    return POS_W'(12);
      IDX_DE_ON:     return POS_W'(16);
      IDX_DE_OFF:    return POS_W'(56);
      IDX_ACT_ON:    return POS_W'(20);
      IDX_ACT_OFF:   return POS_W'(52);
      IDX_VS_END_LN: return POS_W'(2);
      IDX_VS_END_PX: return POS_W'(30);
      IDX_FRAME_MAX: return POS_W'(15);
      IDX_VDE_ON:    return POS_W'(3);
      IDX_VDE_OFF:   return POS_W'(13);
      default:       return '0;
    endcase
  endfunction

  function automatic cfg_vec_t resetCfg();
    cfg_vec_t c;
    for (int i = 0; i < NUM_POS; i++) c[i] = resetPos(i);
    return c;
  endfunction

  // Half-open window test; an empty or inverted window never matches
  function automatic logic inSpan(input pos_t p, input pos_t on, input pos_t off);
    return (on < off) && (p >= on) && (p < off);
  endfunction
endpackage

// File: rtl/ptg_regs.sv
`timescale 1ns/1ps
module ptg_regs
  import ptg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 218
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              loadEn,
  output cfg_vec_t          activeCfg
);
  localparam int SPAN  = 2 * NUM_POS;
  localparam int IDX_W = $clog2(NUM_POS);
  localparam int OFF_W = ADDR_W + 1;

  logic [OFF_W-1:0] addrExt;
  logic [OFF_W-1:0] offset;
  logic             hit;
  logic [IDX_W-1:0] wrIdx;
  logic             wrHigh;
  pos_t             stageArr [NUM_POS];
  cfg_vec_t         stageCfg;

  assign addrExt = {1'b0, wrAddr};
  assign offset  = addrExt - OFF_W'(BASE_ADDR);
  assign hit     = wrEn && (addrExt >= OFF_W'(BASE_ADDR)) && (offset < OFF_W'(SPAN));
  assign wrIdx   = offset[IDX_W:1];
  assign wrHigh  = offset[0];

  for (genvar k = 0; k < NUM_POS; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stageArr[k] <= resetPos(k);
      end else if (hit && (wrIdx == IDX_W'(k))) begin
        if (wrHigh) stageArr[k][POS_W-1:BYTE_W] <= wrData[HI_W-1:0];
        else        stageArr[k][BYTE_W-1:0]     <= wrData;
      end
    end
    assign stageCfg[k] = stageArr[k];
  end

  // Working set switches as a whole on the frame wrap
  always_ff @(posedge clk) begin
    if (rst)         activeCfg <= resetCfg();
    else if (loadEn) activeCfg <= stageCfg;
  end
endmodule

// File: rtl/ptg_ctrl.sv
`timescale 1ns/1ps
module ptg_ctrl
  import ptg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pos_t        lineMax,
  input  pos_t        frameMax,
  output ptg_strobe_t strobes
);
  pos_t hCnt;
  pos_t vCnt;
  logic lineEnd;
  logic frameEnd;

  assign lineEnd  = (hCnt >= lineMax);
  assign frameEnd = lineEnd && (vCnt >= frameMax);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= frameEnd ? '0 : vCnt + POS_W'(1);
    end else begin
      hCnt <= hCnt + POS_W'(1);
    end
  end

  always_comb begin
    strobes.hCnt      = hCnt;
    strobes.vCnt      = vCnt;
    strobes.lineWrap  = lineEnd && !rst;
    strobes.frameWrap = frameEnd && !rst;
  end
endmodule

// File: rtl/ptg_datapath.sv
`timescale 1ns/1ps
module ptg_datapath
  import ptg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ptg_strobe_t strobes,
  input  cfg_vec_t    cfg,
  output logic        hSync,
  output logic        vSync,
  output logic        dataEn,
  output logic        activeVid,
  output pos_t        pixCount,
  output pos_t        lineCount
);
  localparam int NUM_WIN = 3;
  localparam int WIN_ON  [NUM_WIN] = '{IDX_HS_ON,  IDX_DE_ON,  IDX_ACT_ON};
  localparam int WIN_OFF [NUM_WIN] = '{IDX_HS_OFF, IDX_DE_OFF, IDX_ACT_OFF};

  logic [NUM_WIN-1:0] hWin;
  logic               vDeLine;
  logic               vsNext;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_hwin
    assign hWin[w] = inSpan(strobes.hCnt, cfg[WIN_ON[w]], cfg[WIN_OFF[w]]);
  end

  assign vDeLine = inSpan(strobes.vCnt, cfg[IDX_VDE_ON], cfg[IDX_VDE_OFF]);

  // Lexicographic compare of (line, pixel) against the programmed end point
  assign vsNext = (strobes.vCnt < cfg[IDX_VS_END_LN]) ||
                  ((strobes.vCnt == cfg[IDX_VS_END_LN]) &&
                   (strobes.hCnt < cfg[IDX_VS_END_PX]));

  always_ff @(posedge clk) begin
    if (rst) begin
      hSync     <= 1'b0;
      vSync     <= 1'b0;
      dataEn    <= 1'b0;
      activeVid <= 1'b0;
      pixCount  <= '0;
      lineCount <= '0;
    end else begin
      hSync     <= hWin[0];
      vSync     <= vsNext;
      dataEn    <= hWin[1] && vDeLine;
      activeVid <= hWin[2] && vDeLine;
      pixCount  <= strobes.hCnt;
      lineCount <= strobes.vCnt;
    end
  end
endmodule

// File: rtl/panel_timing_gen.sv
`timescale 1ns/1ps
module panel_timing_gen
  import ptg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 218
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic              hSync,
  output logic              vSync,
  output logic              dataEn,
  output logic              activeVid,
  output logic [10:0]       pixCount,
  output logic [10:0]       lineCount
);
  cfg_vec_t    activeCfg;
  ptg_strobe_t strobes;

  ptg_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (regWrEn),
    .wrAddr    (regAddr),
    .wrData    (regWrData),
    .loadEn    (strobes.frameWrap),
    .activeCfg (activeCfg)
  );

  ptg_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .lineMax  (activeCfg[IDX_LINE_MAX]),
    .frameMax (activeCfg[IDX_FRAME_MAX]),
    .strobes  (strobes)
  );

  ptg_datapath i_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .cfg       (activeCfg),
    .hSync     (hSync),
    .vSync     (vSync),
    .dataEn    (dataEn),
    .activeVid (activeVid),
    .pixCount  (pixCount),
    .lineCount (lineCount)
  );
endmodule

// File: rtl/ptg_checker.sv
`timescale 1ns/1ps
module ptg_checker
  import ptg_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     hSync,
  input logic     vSync,
  input logic     dataEn,
  input logic     activeVid,
  input pos_t     pixCount,
  input pos_t     lineCount,
  input logic     frameWrap,
  input cfg_vec_t cfg
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!hSync && !vSync && !dataEn && !activeVid && pixCount == '0 && lineCount == '0));

  assert_cfg_at_frame_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cfg) && !$past(rst)) |-> $past(frameWrap));

  assert_pix_step_R4: assert property (@(posedge clk) disable iff (rst)
    (pixCount != '0) |-> (pixCount == $past(pixCount) + POS_W'(1)));

  assert_de_lines_R6: assert property (@(posedge clk) disable iff (rst)
    dataEn |-> (lineCount >= $past(cfg[IDX_VDE_ON]) && lineCount < $past(cfg[IDX_VDE_OFF])));

  assert_act_pixels_R7: assert property (@(posedge clk) disable iff (rst)
    activeVid |-> (pixCount >= $past(cfg[IDX_ACT_ON]) && pixCount < $past(cfg[IDX_ACT_OFF])));

  assert_vs_begin_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(vSync) |-> (pixCount == '0 && lineCount == '0));

  assert_hs_empty_R9: assert property (@(posedge clk) disable iff (rst)
    $past(cfg[IDX_HS_OFF] <= cfg[IDX_HS_ON]) |-> !hSync);
endmodule

bind panel_timing_gen ptg_checker u_ptgChecker (
  .clk       (clk),
  .rst       (rst),
  .hSync     (hSync),
  .vSync     (vSync),
  .dataEn    (dataEn),
  .activeVid (activeVid),
  .pixCount  (pixCount),
  .lineCount (lineCount),
  .frameWrap (strobes.frameWrap),
  .cfg       (activeCfg)
);

// File: tb/test_panel_timing_gen.sv
`timescale 1ns/1ps
module test_panel_timing_gen;
  localparam int BASE = 218;
  localparam int NPOS = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        hSync, vSync, dataEn, activeVid;
  logic [10:0] pixCount, lineCount;

  int checkCnt = 0;
  int failCnt  = 0;
  string phase = "R1";

  int mStage [NPOS];
  int mCfg   [NPOS];
  int mH = 0, mV = 0;
  int eP, eL;
  bit eHs, eVs, eDe, eAct;
  int hsHigh, deHigh, maxPix;

  always #10 clk = ~clk;

  panel_timing_gen i_panel_timing_gen (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn), .activeVid(activeVid),
    .pixCount(pixCount), .lineCount(lineCount)
  );

  function automatic int defVal(input int i);
    case (i)
      0: return 63;  1: return 4;   2: return 12;  3: return 16;
      4: return 56;  5: return 20;  6: return 52;  7: return 2;
      8: return 30;  9: return 15;  10: return 3;  11: return 13;
      default: return 0;
    endcase
  endfunction

  function automatic bit span(input int p, input int on, input int off);
    return (on < off) && (p >= on) && (p < off);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s (phase %s) at %0t: actual %0d expected %0d", tag, phase, $time, act, exp);
    end
  endtask

  // One clock: drive inputs, advance the reference model, compare away from the edge
  task automatic step(input bit doWr, input int a, input int d);
    bit lineEnd, frameEnd, vde;
    regWrEn = doWr; regAddr = 8'(a); regWrData = 8'(d);
    @(posedge clk);
    if (rst) begin
      eP = 0; eL = 0; eHs = 0; eVs = 0; eDe = 0; eAct = 0;
      mH = 0; mV = 0;
      for (int i = 0; i < NPOS; i++) begin mCfg[i] = defVal(i); mStage[i] = defVal(i); end
    end else begin
      eP = mH; eL = mV;
      vde  = span(mV, mCfg[10], mCfg[11]);
      eHs  = span(mH, mCfg[1], mCfg[2]);
      eDe  = span(mH, mCfg[3], mCfg[4]) && vde;
      eAct = span(mH, mCfg[5], mCfg[6]) && vde;
      eVs  = (mV < mCfg[7]) || (mV == mCfg[7] && mH < mCfg[8]);
      lineEnd  = (mH >= mCfg[0]);
      frameEnd = lineEnd && (mV >= mCfg[9]);
      if (frameEnd) for (int i = 0; i < NPOS; i++) mCfg[i] = mStage[i];
      if (lineEnd) begin mH = 0; mV = frameEnd ? 0 : mV + 1; end
      else mH = mH + 1;
      if (doWr && a >= BASE && a < BASE + 2 * NPOS) begin
        if ((a - BASE) % 2 == 1) mStage[(a - BASE) / 2] = (mStage[(a - BASE) / 2] & 255) | ((d & 7) << 8);
        else                     mStage[(a - BASE) / 2] = (mStage[(a - BASE) / 2] & 1792) | (d & 255);
      end
    end
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R4 pixCount", int'(pixCount), eP);
    chk("R4 lineCount", int'(lineCount), eL);
    chk("R5 hSync", int'(hSync), int'(eHs));
    chk("R6 dataEn", int'(dataEn), int'(eDe));
    chk("R7 activeVid", int'(activeVid), int'(eAct));
    chk("R8 vSync", int'(vSync), int'(eVs));
    if (hSync) hsHigh++;
    if (dataEn) deHigh++;
    if (int'(pixCount) > maxPix) maxPix = int'(pixCount);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  // Writes one position as a byte pair; junk in the upper high-byte bits (R2)
  task automatic wrPos(input int idx, input int val);
    step(1'b1, BASE + 2 * idx, val & 255);
    step(1'b1, BASE + 2 * idx + 1, 8'hA8 | ((val >> 8) & 7));
  endtask

  task automatic strayWrite();
    int a;
    a = ($urandom % 2) ? (BASE - 1 - int'($urandom % 20)) : (BASE + 2 * NPOS + int'($urandom % 10));
    step(1'b1, a, int'($urandom % 256));
  endtask

  initial begin
    int lm, fm;
    int vals [NPOS];
    void'($urandom(32'd20240611));
    for (int i = 0; i < NPOS; i++) begin mCfg[i] = defVal(i); mStage[i] = defVal(i); end

    // R1: reset state
    phase = "R1";
    rst = 1'b1;
    idle(4);
    chk("R1 hSync low in reset", int'(hSync), 0);
    chk("R1 vSync low in reset", int'(vSync), 0);
    rst = 1'b0;
    phase = "R4";
    idle(1);
    chk("R4 first output pixel", int'(pixCount), 0);
    chk("R8 vSync at line 0 pixel 0", int'(vSync), 1);
    idle(60);

    // R2/R3: stage config A while default frame runs
    phase = "R2";
    vals = '{19, 2, 5, 3, 17, 5, 15, 1, 7, 9, 2, 8};
    for (int i = 0; i < NPOS; i++) begin
      wrPos(i, vals[i]);
      strayWrite();
    end
    phase = "R3";
    maxPix = 0;
    idle(100);
    chk("R3 old line length kept before boundary", maxPix, 63);
    idle(1000);

    // R3: mid-frame low-byte update must wait for the boundary
    for (int i = 0; i < 400 && !(pixCount == 11'd0 && lineCount == 11'd1); i++) idle(1);
    step(1'b1, BASE, 9);
    maxPix = 0;
    idle(25);
    chk("R3 line length unchanged mid-frame", maxPix, 19);
    idle(250);
    maxPix = 0;
    idle(40);
    chk("R3 new line length after boundary", maxPix, 9);

    // R9: empty and inverted windows
    phase = "R9";
    wrPos(1, 5); wrPos(2, 5);
    wrPos(3, 10); wrPos(4, 4);
    idle(150);
    hsHigh = 0; deHigh = 0;
    idle(100);
    chk("R9 hSync stays low for hsOn==hsOff", hsHigh, 0);
    chk("R9 dataEn stays low for deOn>deOff", deHigh, 0);

    // Random timing sets with stray writes
    phase = "R5";
    for (int c = 0; c < 8; c++) begin
      lm = 6 + int'($urandom % 30);
      fm = 3 + int'($urandom % 8);
      for (int i = 0; i < NPOS; i++) begin
        case (i)
          0:  vals[i] = lm;
          9:  vals[i] = fm;
          7:  vals[i] = int'($urandom % (fm + 2));
          10, 11: vals[i] = int'($urandom % (fm + 3));
          default: vals[i] = int'($urandom % (lm + 3));
        endcase
      end
      for (int i = 0; i < NPOS; i++) begin
        wrPos(i, vals[i]);
        if ($urandom % 4 == 0) strayWrite();
      end
      idle(900);
    end

    // Directed vs end inside a line (R8)
    phase = "R8";
    wrPos(0, 15); wrPos(9, 4); wrPos(7, 2); wrPos(8, 11);
    idle(1000);

    // R1: reset in mid-frame
    phase = "R1";
    idle(7);
    rst = 1'b1;
    idle(3);
    chk("R1 pixCount cleared", int'(pixCount), 0);
    chk("R1 dataEn cleared", int'(dataEn), 0);
    rst = 1'b0;
    phase = "R4";
    idle(300);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule